// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends data words as asynchronous serial frames on a single TX line. A write places a word in a holding buffer. When the output shift register is idle and sending is enabled, the word moves into the shift register and the buffer is free again. A second word can therefore be written while the first frame is still on the line.

Each frame has four parts, in this order on the line: a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The line idles high. Configuration inputs set the following:
- the data length: seven, eight or nine bits;
- whether a parity bit is sent, and whether it is even or odd;
- the number of stop bits;
- which event raises the interrupt request.

A reload-counter baud generator advances only on cycles where the count-source enable is high. It makes every bit last 16·(n+1) source ticks.

The block has four status outputs:
- buffer-empty;
- transmitter-empty;
- a sticky overrun flag, for a write that arrived while the buffer was full;
- a sticky interrupt request, which stays set until it is acknowledged.

Top module: `uart_dbl_tx`

## Requirements
- R1: With divider value n on `div_i`, every bit on `txd_o` lasts exactly 16·(n+1) cycles in which `src_en_i` is high. Cycles where `src_en_i` is low do not advance the bit timing.
- R2: The line is high when idle. A frame sends a 0 start bit, then the data bits with D0 first, then the stop bits, which are 1.
- R3: `len_i` selects the data length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 gives 9 bits. Data bits above the selected length are not sent.
- R4: When `par_en_i` is 1, a parity bit follows the last data bit. With `par_odd_i`=0 the count of ones in data plus parity is even. With `par_odd_i`=1 that count is odd.
- R5: When `stop2_i` is 0 the frame ends with one stop bit. When `stop2_i` is 1 it ends with two stop bits.
- R6: A written word moves from the buffer to the shift register when the shifter is idle or finishing a frame. After that move, `buf_empty_o` is 1 while the frame is sent. If the buffer is full when the last stop bit ends, the next start bit follows with no idle gap.
- R7: `tx_empty_o` is 1 only when both the buffer and the shift register are empty. It is 0 while a frame is being sent.
- R8: When `irq_sel_i`=0, `irq_o` is set in the cycle after a word leaves the buffer for the shift register.
- R9: When `irq_sel_i`=1, `irq_o` is set in the cycle after the last stop bit ends with the buffer empty. It is not set while the frame is being sent.
- R10: `irq_o` stays 1 until `irq_ack_i` is high. If a new set event and an acknowledge occur in the same cycle, the set wins.
- R11: When `tx_en_i` is 0, the frame in progress finishes and no new frame starts. A word left in the buffer is sent once `tx_en_i` returns to 1.
- R12: A write while the buffer is full, and not in the handover cycle, is ignored and sets `overrun_o`. `overrun_o` stays set until `ovr_clr_i` is high. A write in the same cycle as the handover is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 1 | Baud count-source enable |
| div_i | input | DIV_W | Baud divider value n |
| tx_en_i | input | 1 | Transmit enable |
| len_i | input | 2 | Data length select (0=7, 1=8, 2/3=9) |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| stop2_i | input | 1 | Two stop bits when 1 |
| irq_sel_i | input | 1 | Interrupt on 0: buffer handover, 1: transmission complete |
| wr_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 9 | Word to send |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| ovr_clr_i | input | 1 | Overrun flag clear |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Holding buffer is empty |
| tx_empty_o | output | 1 | Buffer and shifter both empty |
| overrun_o | output | 1 | Sticky write-while-full flag |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The buffer handover and a new write can fall in the same cycle. The bench provokes this by filling the buffer with the transmitter disabled. It then raises the enable and a second write strobe on the same edge. It judges the result by confirming three things:
- the overrun flag stays clear;
- the buffer stays full;
- both words come out as consecutive frames.

The same edge also carries an interrupt acknowledge while a buffer-empty interrupt is being raised. The bench expects the request to remain set afterwards.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_MAX  = 9;
  localparam int unsigned FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int unsigned OVS       = 16;

  typedef enum logic [1:0] {
    LEN_7 = 2'd0,
    LEN_8 = 2'd1,
    LEN_9 = 2'd2
  } len_e;

  function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] len);
    case (len)
      LEN_7:   return CNT_W'(7);
      LEN_8:   return CNT_W'(8);
      default: return CNT_W'(9);
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             src_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  import uart_tx_pkg::*;
  localparam int unsigned SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (!run_i) begin
      cnt_q <= div_i;
      sub_q <= '0;
    end else if (src_en_i) begin
      if (cnt_q == '0) begin
        cnt_q <= div_i;
        sub_q <= sub_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick_o = run_i && src_en_i && (cnt_q == '0) && (sub_q == SUB_W'(OVS - 1));

  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [8:0] data_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       stop2_i,
  input  logic       tick_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       txd_o
);
  import uart_tx_pkg::*;
  localparam int unsigned FW = FRAME_MAX;

  logic [FW-1:0]    sr_q, frame;
  logic [CNT_W-1:0] left_q, nd, total;
  logic             busy_q, par;

  // Assemble the frame LSB-first: start, data, parity, stops (stops come from the '1 fill)
  always_comb begin
    nd    = data_bits(len_i);
    frame = '1;
    frame[0] = 1'b0;
    par   = par_odd_i;
    for (int j = 0; j < int'(DATA_MAX); j++) begin
      if (CNT_W'(j) < nd) begin
        frame[j+1] = data_i[j];
        par        = par ^ data_i[j];
      end
    end
    if (par_en_i) frame[nd + CNT_W'(1)] = par;
    total = CNT_W'(2) + nd + CNT_W'(par_en_i) + CNT_W'(stop2_i);
  end

  assign done_o = busy_q && tick_i && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame;
      left_q <= total;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      sr_q   <= {1'b1, sr_q[FW-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sr_q[0] : 1'b1;

  // R2
  start_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o && !txd_o);
  // R1
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(txd_o));
endmodule

// File: rtl/uart_dbl_tx.sv
module uart_dbl_tx #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_en_i,
  input  logic [1:0]       len_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             irq_sel_i,
  input  logic             wr_i,
  input  logic [8:0]       wr_data_i,
  input  logic             irq_ack_i,
  input  logic             ovr_clr_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             tx_empty_o,
  output logic             overrun_o,
  output logic             irq_o
);
  logic [8:0] buf_q;
  logic       full_q, irq_q, ovr_q;
  logic       busy, done, tick, load, wr_acc, irq_set;

  assign load    = tx_en_i && full_q && (!busy || done);
  assign wr_acc  = wr_i && (!full_q || load);
  assign irq_set = irq_sel_i ? (done && !full_q) : load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_acc) buf_q <= wr_data_i;
      if (wr_acc)    full_q <= 1'b1;
      else if (load) full_q <= 1'b0;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
      if (wr_i && !wr_acc) ovr_q <= 1'b1;
      else if (ovr_clr_i)  ovr_q <= 1'b0;
    end
  end

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .src_en_i(src_en_i),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  uart_tx_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .data_i   (buf_q),
    .len_i    (len_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .stop2_i  (stop2_i),
    .tick_i   (tick),
    .busy_o   (busy),
    .done_o   (done),
    .txd_o    (txd_o)
  );

  assign buf_empty_o = !full_q;
  assign tx_empty_o  = !full_q && !busy;
  assign overrun_o   = ovr_q;
  assign irq_o       = irq_q;

  // R7
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);
  // R8
  irq_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_sel_i && load |=> irq_o);
  // R11
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i && !busy |=> !busy);
  // R12
  ovr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full_q && !load |=> $stable(buf_q) && overrun_o);
endmodule

// File: tb/sim_uart_dbl_tx.sv
`timescale 1ns/1ps
module sim_uart_dbl_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_en = 1'b1, src_tgl = 1'b0;
  logic [7:0] div = 8'd1;
  logic       tx_en = 1'b1;
  logic [1:0] len = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, irq_sel = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wr_data = '0;
  logic       irq_ack = 1'b0, ovr_clr = 1'b0;
  logic       txd, buf_empty, tx_empty, overrun, irq;

  int errors = 0, checks = 0, bp = 32;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) src_en <= src_tgl ? ~src_en : 1'b1;

  uart_dbl_tx #(.DIV_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .div_i(div), .tx_en_i(tx_en),
    .len_i(len), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .irq_sel_i(irq_sel), .wr_i(wr), .wr_data_i(wr_data), .irq_ack_i(irq_ack),
    .ovr_clr_i(ovr_clr), .txd_o(txd), .buf_empty_o(buf_empty), .tx_empty_o(tx_empty),
    .overrun_o(overrun), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  function automatic void exp_frame(input logic [8:0] d, output logic [15:0] v, output int n);
    int nd, k, ones;
    nd = (len == 2'd0) ? 7 : (len == 2'd1) ? 8 : 9;
    v = '0; k = 0; ones = 0;
    v[k++] = 1'b0;
    for (int i = 0; i < nd; i++) begin v[k++] = d[i]; ones += int'(d[i]); end
    if (par_en) v[k++] = par_odd ? ~ones[0] : ones[0];
    v[k++] = 1'b1;
    if (stop2) v[k++] = 1'b1;
    n = k;
  endfunction

  task automatic write(input logic [8:0] d);
    @(negedge clk); wr = 1'b1; wr_data = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rx_frame(input int n, output logic [15:0] v, output longint t0);
    v = '0;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (bp / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (bp) @(negedge clk);
      v[k] = txd;
    end
  endtask

  task automatic frame_chk(input logic [8:0] d, input string req);
    logic [15:0] e, g; int n; longint t0;
    exp_frame(d, e, n);
    rx_frame(n, g, t0);
    chk(g == e, req, g, e);
  endtask

  task automatic wait_idle();
    int lim = 4000;
    @(negedge clk);
    while (!tx_empty && lim > 0) begin @(negedge clk); lim--; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd === 1'b1, "R2 idle line", txd, 1);
    chk(buf_empty === 1'b1 && tx_empty === 1'b1, "R7 reset empty", {buf_empty, tx_empty}, 3);
    chk(irq === 1'b0 && overrun === 1'b0, "R10 reset flags", {irq, overrun}, 0);
  endtask

  task automatic t_8n1();
    logic [15:0] e, g; int n; longint t0;
    len = 2'd1; par_en = 0; stop2 = 0;
    write(9'h0A5);
    chk(buf_empty === 1'b0 && tx_empty === 1'b0, "R7 not empty after write", {buf_empty, tx_empty}, 0);
    exp_frame(9'h0A5, e, n);
    rx_frame(n, g, t0);
    chk(g == e, "R2 8N1 frame", g, e);
    chk(buf_empty === 1'b1 && tx_empty === 1'b0, "R6 buffer freed while sending", {buf_empty, tx_empty}, 2);
    repeat (bp) @(negedge clk);
    chk(tx_empty === 1'b1 && txd === 1'b1, "R7 empty after frame", {tx_empty, txd}, 3);
  endtask

  task automatic t_formats();
    len = 2'd0; par_en = 1; par_odd = 0; stop2 = 1;
    write(9'h0D3); frame_chk(9'h0D3, "R3 R4 R5 7E2 frame"); wait_idle();
    len = 2'd2; par_en = 1; par_odd = 1; stop2 = 0;
    write(9'h1A5); frame_chk(9'h1A5, "R3 R4 9O1 frame"); wait_idle();
    len = 2'd1; par_en = 1; par_odd = 0; stop2 = 0;
    write(9'h1F0); frame_chk(9'h1F0, "R3 R4 8E1 drops D8"); wait_idle();
    len = 2'd3; par_en = 0; stop2 = 1;
    write(9'h155); frame_chk(9'h155, "R3 R5 9N2 frame"); wait_idle();
    len = 2'd1; par_en = 0; stop2 = 0;
  endtask

  task automatic t_baud(input logic [7:0] n, input bit tgl, input longint exp);
    longint t1, t2, lim;
    div = n; src_tgl = tgl;
    bp = int'(exp);
    write(9'h001);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    lim = 0;
    while (txd !== 1'b1 && lim < 1000) begin @(negedge clk); lim++; end
    t1 = cyc;
    while (txd !== 1'b0 && lim < 2000) begin @(negedge clk); lim++; end
    t2 = cyc;
    chk(t2 - t1 == exp, "R1 bit period", t2 - t1, exp);
    wait_idle();
    src_tgl = 0; div = 8'd1; bp = 32;
  endtask

  task automatic t_b2b();
    logic [15:0] ea, eb, ga, gb; int n; longint ta, tb;
    irq_sel = 0; tx_en = 0;
    write(9'h03C);
    exp_frame(9'h03C, ea, n); exp_frame(9'h0C3, eb, n);
    @(negedge clk); tx_en = 1;
    fork
      begin rx_frame(n, ga, ta); rx_frame(n, gb, tb); end
      begin
        repeat (3) @(negedge clk);
        chk(irq === 1'b1, "R8 irq on handover", irq, 1);
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk(irq === 1'b0, "R10 ack clears", irq, 0);
        write(9'h0C3);
        chk(buf_empty === 1'b0, "R6 second word buffered", buf_empty, 0);
      end
    join
    chk(ga == ea && gb == eb, "R6 both frames", {ga, gb}, {ea, eb});
    chk(tb - ta == longint'(n * bp), "R6 no gap", tb - ta, n * bp);
    chk(irq === 1'b1, "R8 irq on second handover", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    wait_idle();
  endtask

  task automatic t_complete();
    logic [15:0] e, g; int n; longint t0;
    irq_sel = 1;
    write(9'h05A);
    exp_frame(9'h05A, e, n);
    rx_frame(n, g, t0);
    chk(irq === 1'b0, "R9 no irq mid-frame", irq, 0);
    repeat (bp / 2 - 1) @(negedge clk);
    chk(irq === 1'b0, "R9 no irq in last stop cycle", irq, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R9 irq at completion", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq === 1'b1, "R10 irq held", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    irq_sel = 0;
    wait_idle();
  endtask

  task automatic t_collide();
    tx_en = 0; irq_sel = 0;
    write(9'h011);
    @(negedge clk);
    tx_en = 1; wr = 1; wr_data = 9'h022; irq_ack = 1;
    @(negedge clk);
    wr = 0; irq_ack = 0;
    chk(overrun === 1'b0, "R12 write on handover accepted", overrun, 0);
    chk(buf_empty === 1'b0, "R12 buffer refilled", buf_empty, 0);
    chk(irq === 1'b1, "R10 set beats ack", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    frame_chk(9'h011, "R12 first frame");
    frame_chk(9'h022, "R12 second frame");
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    wait_idle();
  endtask

  task automatic t_overrun();
    tx_en = 0;
    write(9'h066);
    write(9'h099);
    chk(overrun === 1'b1, "R12 overrun set", overrun, 1);
    repeat (3) @(negedge clk);
    chk(overrun === 1'b1, "R12 overrun sticky", overrun, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(overrun === 1'b0, "R12 overrun cleared", overrun, 0);
    tx_en = 1;
    frame_chk(9'h066, "R12 ignored write");
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    wait_idle();
  endtask

  task automatic t_disable();
    logic [15:0] e, g; int n; longint t0; bit high;
    tx_en = 1;
    write(9'h0F0);
    exp_frame(9'h0F0, e, n);
    fork
      rx_frame(n, g, t0);
      begin repeat (3 * bp) @(negedge clk); write(9'h00F); tx_en = 0; end
    join
    chk(g == e, "R11 frame in progress completes", g, e);
    high = 1;
    repeat (3 * bp) begin @(negedge clk); if (txd !== 1'b1) high = 0; end
    chk(high, "R11 no new frame", high, 1);
    chk(buf_empty === 1'b0 && tx_empty === 1'b0, "R11 word pending", {buf_empty, tx_empty}, 0);
    tx_en = 1;
    frame_chk(9'h00F, "R11 pending word sent");
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_8n1();
    t_formats();
    t_baud(8'd0, 1'b0, 16);
    t_baud(8'd3, 1'b1, 128);
    t_b2b();
    t_complete();
    t_collide();
    t_overrun();
    t_disable();
    finish_run();
  end
endmodule